// File: doc/BRIEF.md
# Sampled Junction Temperature Estimator

This block turns a stream of sampled power values into a junction temperature estimate. Each accepted power sample is pushed into a history of the last N samples. A single multiply-accumulate engine then walks that history against a loaded table of thermal-impedance step increments, adds the programmed ambient temperature, and presents the result with a one-cycle done pulse.

The table is filled offline through a simple write port. Entry j holds the rise of the transient impedance between taps j and j+1, at the same sample spacing as the power stream. Alongside the estimate, the block keeps a running maximum. It flags that maximum whenever it exceeds the junction ceiling less a programmable safety margin. A synchronous clear starts a new observation without touching the table.

The conversion takes N+1 clock cycles. With the default depth, either a 100 µs or a 1 ms strobe period leaves the engine idle for most of each period at any clock above a few MHz.

Top module: `thermal_conv`

## Requirements
- R1: On completion, temp_o equals ambient plus the scaled sum over j=0..N-1 of hist[j]·dz[j]. Here hist[0] is the newest accepted power sample, hist[j] is the sample accepted j strobes earlier (zero if none since clear or reset), and dz[j] is table entry j.
- R2: A power sample accepted N or more strobes ago contributes nothing, because the impedance is held at its final tabulated value. Constant power P applied for at least N samples therefore yields ambient + (P·Σdz)/2^16.
- R3: The 40-bit sum of products is shifted right by 16 and added to amb_i (unsigned, 1/16 °C units). The result saturates at 65535, so temp_o is never below the ambient sampled on the completing edge.
- R4: A strobe seen while idle is accepted. done_o is high for exactly one cycle, N clock edges after the accepting edge. temp_o holds its value until the next completion or clear.
- R5: A strobe that arrives while a conversion is running is ignored. It neither enters the history nor changes any result.
- R6: peak_o is the maximum of all completed estimates since clear or reset. It is updated on the edge after done_o.
- R7: over_o is high exactly when peak_o > tjmax_i − 16·m, where m is margin_i (whole °C) clamped to the range 15..25. When tjmax_i < 16·m, the limit is taken as 0.
- R8: While clr_i is high on an edge, the history, the accumulator, temp_o, peak_o and done_o are cleared, and any running conversion is abandoned. The table is kept.
- R9: After asynchronous reset, temp_o, peak_o and done_o are zero, and the history and table are all zero.
- R10: A table write with z_we_i high stores z_data_i at entry z_addr_i (0..N−1) on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of history, accumulator and peak |
| p_valid_i | input | 1 | Power sample strobe |
| p_data_i | input | 16 | Unsigned power sample |
| amb_i | input | 16 | Ambient temperature, 1/16 °C |
| tjmax_i | input | 16 | Junction ceiling, 1/16 °C |
| margin_i | input | 5 | Safety margin in whole °C, clamped to 15..25 |
| z_we_i | input | 1 | Table write enable |
| z_addr_i | input | 6 | Table write index |
| z_data_i | input | 16 | Impedance increment to store |
| temp_o | output | 16 | Latest temperature estimate, 1/16 °C |
| done_o | output | 1 | One-cycle pulse when temp_o is updated |
| peak_o | output | 16 | Running maximum estimate, 1/16 °C |
| over_o | output | 1 | Peak above ceiling minus margin |

## Verification
After the accepting edge, the estimate and the done pulse are due on the Nth following edge. The peak follows one edge later. The limit flag is combinational on peak_o, tjmax_i and margin_i, so it is due in the same cycle as they change. The bench counts edges from the one that takes the strobe, and samples 1 ns after each edge. It checks that done_o is low one edge before it is due, high on the due edge and low again after it, reads temp_o on the due edge and peak_o on the edge after. It reads the flag after each change of tjmax_i and margin_i, still away from the clock.

// File: rtl/thermal_conv_pkg.sv
package thermal_conv_pkg;
  localparam int unsigned TEMP_FRAC  = 4;
  localparam int unsigned MARGIN_MIN = 15;
  localparam int unsigned MARGIN_MAX = 25;
endpackage

// File: rtl/tc_history.sv
module tc_history #(
  parameter int unsigned N  = 64,
  parameter int unsigned PW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 shift_i,
  input  logic [PW-1:0]        din_i,
  input  logic [$clog2(N)-1:0] rd_idx_i,
  output logic [PW-1:0]        rd_o
);
  logic [PW-1:0] mem [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mem[0] <= '0;
    else if (clr_i)   mem[0] <= '0;
    else if (shift_i) mem[0] <= din_i;
  end

  for (genvar g = 1; g < N; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mem[g] <= '0;
      else if (clr_i)   mem[g] <= '0;
      else if (shift_i) mem[g] <= mem[g-1];
    end
  end

  assign rd_o = mem[rd_idx_i];
endmodule

// File: rtl/tc_ztable.sv
module tc_ztable #(
  parameter int unsigned N  = 64,
  parameter int unsigned ZW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [$clog2(N)-1:0] waddr_i,
  input  logic [ZW-1:0]        wdata_i,
  input  logic [$clog2(N)-1:0] raddr_i,
  output logic [ZW-1:0]        rdata_o
);
  logic [ZW-1:0] tbl [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) tbl[i] <= '0;
    end else if (we_i) begin
      tbl[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = tbl[raddr_i];
endmodule

// File: rtl/tc_mac.sv
module tc_mac #(
  parameter int unsigned N    = 64,
  parameter int unsigned PW   = 16,
  parameter int unsigned ZW   = 16,
  parameter int unsigned AW   = 40,
  parameter int unsigned TW   = 16,
  parameter int unsigned FRAC = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 start_i,
  input  logic [PW-1:0]        p_i,
  input  logic [ZW-1:0]        z_i,
  input  logic [TW-1:0]        amb_i,
  output logic                 busy_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 done_o,
  output logic [TW-1:0]        temp_o
);
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned SW = AW - FRAC + 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic                busy_q, done_q;
  logic [IW-1:0]       idx_q;
  logic [AW-1:0]       acc_q, sum;
  logic [PW+ZW-1:0]    prod;
  logic [SW-1:0]       tsum;
  logic [TW-1:0]       tsat;

  assign prod = p_i * z_i;
  assign sum  = acc_q + AW'(prod);
  assign tsum = {1'b0, sum[AW-1:FRAC]} + SW'(amb_i);
  assign tsat = (tsum > SW'({TW{1'b1}})) ? {TW{1'b1}} : tsum[TW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; idx_q <= '0; acc_q <= '0; temp_o <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0; done_q <= 1'b0; idx_q <= '0; acc_q <= '0; temp_o <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          acc_q  <= '0;
        end
      end else if (idx_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        temp_o <= tsat;
      end else begin
        acc_q <= sum;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/tc_peak.sv
module tc_peak
  import thermal_conv_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned MW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] tjmax_i,
  input  logic [MW-1:0] margin_i,
  output logic [TW-1:0] peak_o,
  output logic          over_o
);
  logic [TW-1:0] peak_q, m_scaled, limit;
  logic [MW-1:0] m_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        peak_q <= '0;
    else if (clr_i)                     peak_q <= '0;
    else if (upd_i && temp_i > peak_q)  peak_q <= temp_i;
  end

  always_comb begin
    if (margin_i < MW'(MARGIN_MIN))      m_eff = MW'(MARGIN_MIN);
    else if (margin_i > MW'(MARGIN_MAX)) m_eff = MW'(MARGIN_MAX);
    else                                 m_eff = margin_i;
  end

  assign m_scaled = TW'(m_eff) << TEMP_FRAC;
  assign limit    = (tjmax_i >= m_scaled) ? tjmax_i - m_scaled : '0;
  assign peak_o   = peak_q;
  assign over_o   = peak_q > limit;
endmodule

// File: rtl/thermal_conv.sv
module thermal_conv #(
  parameter int unsigned N    = 64,
  parameter int unsigned PW   = 16,
  parameter int unsigned ZW   = 16,
  parameter int unsigned AW   = 40,
  parameter int unsigned TW   = 16,
  parameter int unsigned FRAC = 16,
  parameter int unsigned MW   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 p_valid_i,
  input  logic [PW-1:0]        p_data_i,
  input  logic [TW-1:0]        amb_i,
  input  logic [TW-1:0]        tjmax_i,
  input  logic [MW-1:0]        margin_i,
  input  logic                 z_we_i,
  input  logic [$clog2(N)-1:0] z_addr_i,
  input  logic [ZW-1:0]        z_data_i,
  output logic [TW-1:0]        temp_o,
  output logic                 done_o,
  output logic [TW-1:0]        peak_o,
  output logic                 over_o
);
  localparam int unsigned IW = $clog2(N);

  logic          busy, accept, mac_done;
  logic [IW-1:0] idx;
  logic [PW-1:0] p_rd;
  logic [ZW-1:0] z_rd;
  logic [TW-1:0] temp;

  assign accept = p_valid_i & ~busy & ~clr_i;

  tc_history #(.N(N), .PW(PW)) i_hist (
    .clk_i, .rst_ni, .clr_i,
    .shift_i (accept),
    .din_i   (p_data_i),
    .rd_idx_i(idx),
    .rd_o    (p_rd)
  );

  tc_ztable #(.N(N), .ZW(ZW)) i_ztbl (
    .clk_i, .rst_ni,
    .we_i   (z_we_i),
    .waddr_i(z_addr_i),
    .wdata_i(z_data_i),
    .raddr_i(idx),
    .rdata_o(z_rd)
  );

  tc_mac #(.N(N), .PW(PW), .ZW(ZW), .AW(AW), .TW(TW), .FRAC(FRAC)) i_mac (
    .clk_i, .rst_ni, .clr_i,
    .start_i(accept),
    .p_i    (p_rd),
    .z_i    (z_rd),
    .amb_i  (amb_i),
    .busy_o (busy),
    .idx_o  (idx),
    .done_o (mac_done),
    .temp_o (temp)
  );

  tc_peak #(.TW(TW), .MW(MW)) i_peak (
    .clk_i, .rst_ni, .clr_i,
    .upd_i   (mac_done),
    .temp_i  (temp),
    .tjmax_i (tjmax_i),
    .margin_i(margin_i),
    .peak_o  (peak_o),
    .over_o  (over_o)
  );

  assign temp_o = temp;
  assign done_o = mac_done;
endmodule

// File: rtl/thermal_conv_chk.sv
module thermal_conv_chk #(
  parameter int unsigned TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          p_valid_i,
  input logic [TW-1:0] amb_i,
  input logic          busy_i,
  input logic          done_o,
  input logic [TW-1:0] temp_o,
  input logic [TW-1:0] peak_o
);
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_temp_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (done_o || $stable(temp_o)));

  assert_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_valid_i && !busy_i && !clr_i) |=> busy_i);

  assert_temp_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (!done_o || temp_o >= $past(amb_i)));

  assert_peak_mono_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> peak_o >= $past(peak_o));

  assert_peak_covers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> peak_o >= $past(temp_o));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (peak_o == '0 && temp_o == '0 && !done_o && !busy_i));
endmodule

bind thermal_conv thermal_conv_chk #(.TW(TW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .p_valid_i(p_valid_i),
  .amb_i    (amb_i),
  .busy_i   (busy),
  .done_o   (done_o),
  .temp_o   (temp_o),
  .peak_o   (peak_o)
);

// File: tb/test_thermal_conv.sv
module test_thermal_conv;
  localparam int N = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        p_valid_i = 1'b0;
  logic [15:0] p_data_i = '0;
  logic [15:0] amb_i = 16'd400;
  logic [15:0] tjmax_i = 16'd2000;
  logic [4:0]  margin_i = 5'd20;
  logic        z_we_i = 1'b0;
  logic [5:0]  z_addr_i = '0;
  logic [15:0] z_data_i = '0;
  logic [15:0] temp_o, peak_o;
  logic        done_o, over_o;

  int     checks = 0;
  int     errors = 0;
  int     cyc = 0;
  longint hist [N];
  longint dz [N];
  longint peak_exp = 0;

  thermal_conv i_thermal_conv (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_temp();
    longint acc = 0;
    longint t;
    for (int j = 0; j < N; j++) acc += hist[j] * dz[j];
    t = longint'(amb_i) + (acc >> 16);
    return (t > 65535) ? 65535 : t;
  endfunction

  function automatic longint model_limit(input longint tj, input int m);
    int cm = (m < 15) ? 15 : (m > 25) ? 25 : m;
    return (tj >= 16 * cm) ? tj - 16 * cm : 0;
  endfunction

  task automatic load_table();
    for (int j = 0; j < N; j++) begin
      @(negedge clk_i);
      z_we_i = 1'b1; z_addr_i = 6'(j); z_data_i = 16'(dz[j]);
    end
    @(negedge clk_i);
    z_we_i = 1'b0;
  endtask

  task automatic do_sample(input logic [15:0] p, input bit inject, input string req);
    longint t;
    @(negedge clk_i);
    p_valid_i = 1'b1; p_data_i = p;
    @(posedge clk_i);
    @(negedge clk_i);
    p_valid_i = 1'b0;
    for (int j = N - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = p;
    for (int c = 1; c < N; c++) begin
      @(posedge clk_i);
      #1;
      if (inject && c == 5) begin p_valid_i = 1'b1; p_data_i = ~p; end
      if (c == 6) p_valid_i = 1'b0;
    end
    chk("R4 done early", done_o, 0);
    @(posedge clk_i);
    #1;
    t = model_temp();
    chk("R4 done due", done_o, 1);
    chk(req, temp_o, t);
    if (t > peak_exp) peak_exp = t;
    @(posedge clk_i);
    #1;
    chk("R4 done single", done_o, 0);
    chk("R6 peak", peak_o, peak_exp);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int dcount;
    for (int j = 0; j < N; j++) begin hist[j] = 0; dz[j] = 0; end

    #22 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 temp", temp_o, 0);
    chk("R9 peak", peak_o, 0);
    chk("R9 done", done_o, 0);
    chk("R9 over", over_o, 0);

    do_sample(16'd50000, 1'b0, "R9 zero table");

    for (int j = 0; j < N; j++) dz[j] = 300 + 20 * (63 - j) + (j % 7) * 3;
    load_table();

    // impulse walks every tap (R1, R10), then drops out of the window (R2)
    do_sample(16'd40000, 1'b0, "R10 impulse tap");
    for (int k = 1; k < N; k++) do_sample(16'd0, 1'b0, "R1 impulse tap");
    do_sample(16'd0, 1'b0, "R2 impulse aged out");
    chk("R2 aged out equals ambient", temp_o, 400);

    // constant power reaches steady value
    for (int k = 0; k < N + 6; k++) do_sample(16'd30000, 1'b0, "R2 steady");
    begin
      longint s = 0;
      for (int j = 0; j < N; j++) s += dz[j];
      chk("R2 steady closed form", temp_o, 400 + ((30000 * s) >> 16));
    end

    // pseudo-random power, ambient changes, strobes during busy
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (k % 10 == 0) amb_i = 16'(300 + 25 * k);
      do_sample(lfsr, k % 3 == 0, (k % 3 == 0) ? "R5 busy strobe ignored" : "R3 mixed power");
    end
    amb_i = 16'd400;

    // limit flag sweep around the peak
    for (int m = 0; m < 32; m++) begin
      for (int d = -2; d <= 2; d++) begin
        longint tj = peak_exp + 16 * ((m < 15) ? 15 : (m > 25) ? 25 : m) + d;
        @(negedge clk_i);
        margin_i = 5'(m); tjmax_i = 16'(tj);
        #1;
        chk("R7 over", over_o, (peak_exp > model_limit(tj, m)) ? 1 : 0);
      end
    end
    @(negedge clk_i);
    tjmax_i = 16'd100; margin_i = 5'd20;
    #1;
    chk("R7 floor at zero", over_o, 1);
    tjmax_i = 16'd65535;
    #1;
    chk("R7 high ceiling", over_o, 0);

    // clear during a running conversion
    @(negedge clk_i);
    p_valid_i = 1'b1; p_data_i = 16'd20000;
    @(negedge clk_i);
    p_valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    chk("R8 temp cleared", temp_o, 0);
    chk("R8 peak cleared", peak_o, 0);
    dcount = 0;
    for (int c = 0; c < N + 4; c++) begin
      @(negedge clk_i);
      if (done_o) dcount++;
    end
    chk("R8 conversion abandoned", dcount, 0);
    for (int j = 0; j < N; j++) hist[j] = 0;
    peak_exp = 0;
    do_sample(16'd12345, 1'b0, "R8 history cleared table kept");

    // saturation
    for (int j = 0; j < N; j++) dz[j] = 65535;
    load_table();
    do_sample(16'hFFFF, 1'b0, "R3 saturate");
    do_sample(16'hFFFF, 1'b0, "R3 saturate");
    chk("R3 saturated value", temp_o, 65535);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule